// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers the interrupt sources of a mixed-signal device into one byte-wide flag register and produces a single interrupt request for the processor. Each implemented flag has an enable bit in a companion mask register. The request output is registered. It is high when any flag is set and its enable bit is set.

The sources are handled in three ways. Two inputs raise a flag on a change of level: a general-purpose input and a bus of hall-sensor flags. Both are watched only while the device is in run mode. A LIN receive line is watched by a small state machine. It raises a flag when the line goes recessive after it has stayed dominant for longer than a programmable number of cycles. The states are `LIN_RECESSIVE` (idle, counter held at zero), `LIN_DOM_COUNT` (counting dominant cycles) and `LIN_DOM_LONG` (the threshold has been passed). The transitions are: dominant seen moves idle to counting; recessive while counting moves back to idle with no event; the count passing the threshold moves counting to long; recessive while long moves back to idle and raises the flag. Three level conditions (over-temperature, under-voltage, over-voltage) set their flags while active, and a clear attempt cannot remove them while the condition lasts. Eleven power-stage fault events set bits in a separate fault register. The power-stage bit of the flag register shows the OR of that register.

Every external input passes through a two-flop synchronizer. Software reaches the registers through a simple single-cycle write port and a combinational read port.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register, the mask register and both fault bytes read 0, the threshold reads its reset value, and `irq` is 0.
- R2: Register map: flags at 0x0A, mask at 0x0B, fault events 7..0 at 0x0C, fault events 10..8 in bits 2..0 at 0x0D, threshold low byte at 0x0E and high byte at 0x0F. Flag bits are: 7 general input, 6 hall, 5 LIN, 4 reserved, 3 over-temperature, 2 under-voltage, 1 over-voltage, 0 power-stage fault. Bit 4 always reads 0 in both the flag and the mask register.
- R3: Bit 7 is set by either a rising or a falling edge of `gp_in` in run mode. Edges while `run_mode` is 0 never set it, including after the return to run mode.
- R4: Bit 6 is set by any change of the `hall_in` value in run mode. Changes while `run_mode` is 0 never set it.
- R5: Bit 5 is set when `lin_rx` returns to 1 after it has been 0 for more than the threshold number of cycles. A shorter low pulse does not set it.
- R6: Writing 1 to bit 7, 6 or 5 of the flag register clears that flag. Writing 0 leaves it unchanged.
- R7: Bits 3, 2 and 1 are set while their condition input is 1. A write-1 clear has no effect while the condition is still 1. After the condition ends the flag stays set until a write-1 clear.
- R8: Bit 0 equals the OR of the 11 fault bits and ignores writes. Each fault bit is set by its `fault_evt` input and cleared by writing 1 to it in the fault bytes.
- R9: `irq` is 1, one cycle after the register state, exactly when some flag bit and the same mask bit are both 1.
- R10: A set event in the same cycle as a write-1 clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_mode | input | 1 | 1 = run mode, 0 = low-power mode |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| gp_in | input | 1 | General-purpose input |
| hall_in | input | 2 | Hall-sensor flag inputs |
| lin_rx | input | 1 | LIN receive line, 0 = dominant |
| hot_in | input | 1 | Over-temperature condition |
| uv_in | input | 1 | Under-voltage condition |
| ov_in | input | 1 | Over-voltage condition |
| fault_evt | input | 11 | Power-stage fault events |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
The assertions check the following on every cycle:
- the reserved bit reads 0;
- the power-stage bit matches the fault register;
- the general-input and hall flags rise only in a cycle that follows run mode;
- the LIN flag rises only out of the long-dominant state;
- an active condition leaves its flag set on the next cycle, whatever is written;
- a write of 0 never clears a flag;
- `irq` is never high without an enabled flag behind it.

Other behaviour can only be shown by the bench's scenarios:
- the short-versus-long dominant pulse decision against a programmed threshold;
- the sweep of every hall transition pair;
- the walk through each fault bit;
- the exhaustive sweep of all 256 mask values against a known flag pattern.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_FLAGS   = 4'hA;
    localparam logic [ADDR_W-1:0] A_MASK    = 4'hB;
    localparam logic [ADDR_W-1:0] A_FAULT_L = 4'hC;
    localparam logic [ADDR_W-1:0] A_FAULT_H = 4'hD;
    localparam logic [ADDR_W-1:0] A_THR_L   = 4'hE;
    localparam logic [ADDR_W-1:0] A_THR_H   = 4'hF;

    localparam int unsigned B_GP   = 7;
    localparam int unsigned B_HALL = 6;
    localparam int unsigned B_LIN  = 5;
    localparam int unsigned B_RSVD = 4;
    localparam int unsigned B_HOT  = 3;
    localparam int unsigned B_UV   = 2;
    localparam int unsigned B_OV   = 1;
    localparam int unsigned B_PSF  = 0;

    // bits held by write-1-to-clear storage in the flag register
    localparam logic [DATA_W-1:0] W1C_BITS = 8'hEE;
    // bits that exist in the mask register
    localparam logic [DATA_W-1:0] MASK_BITS = 8'hEF;

    typedef enum logic [1:0] {
        LIN_RECESSIVE = 2'd0,
        LIN_DOM_COUNT = 2'd1,
        LIN_DOM_LONG  = 2'd2
    } lin_state_t;

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int unsigned W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= d_in[i];
                stab_q <= meta_q;
            end
        end
        assign d_out[i] = stab_q;
    end
endmodule

// File: rtl/irq_lin_monitor.sv
module irq_lin_monitor
    import irq_flag_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lin_s,
    input  logic [CNT_W-1:0] thr,
    output logic             long_evt,
    output lin_state_t       state
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    lin_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dom;

    assign dom   = ~lin_s;
    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LIN_RECESSIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        long_evt = 1'b0;
        unique case (state_q)
            LIN_RECESSIVE: begin
                cnt_d = '0;
                if (dom) begin
                    state_d = LIN_DOM_COUNT;
                    cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
                end
            end
            LIN_DOM_COUNT: begin
                if (!dom) begin
                    state_d = LIN_RECESSIVE;
                    cnt_d   = '0;
                end else if (cnt_q > thr) begin
                    state_d = LIN_DOM_LONG;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            LIN_DOM_LONG: begin
                if (!dom) begin
                    state_d  = LIN_RECESSIVE;
                    cnt_d    = '0;
                    long_evt = 1'b1;
                end
            end
            default: begin
                state_d = LIN_RECESSIVE;
                cnt_d   = '0;
            end
        endcase
    end
endmodule

// File: rtl/irq_fault_bank.sv
module irq_fault_bank #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] bits_q,
    output logic         any
);
    for (genvar i = 0; i < W; i++) begin : g_fault
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bits_q[i] <= 1'b0;
            else if (set_vec[i]) bits_q[i] <= 1'b1;
            else if (clr_vec[i]) bits_q[i] <= 1'b0;
        end
    end
    assign any = |bits_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int unsigned HALL_W  = 2,
    parameter int unsigned FAULT_W = 11,
    parameter int unsigned CNT_W   = 16,
    parameter logic [15:0] THR_RST = 16'd64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_mode,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               gp_in,
    input  logic [HALL_W-1:0]  hall_in,
    input  logic               lin_rx,
    input  logic               hot_in,
    input  logic               uv_in,
    input  logic               ov_in,
    input  logic [FAULT_W-1:0] fault_evt,
    output logic               irq
);
    localparam int unsigned SYNC_W = 1 + HALL_W + 3 + FAULT_W;

    // synchronized inputs
    logic [SYNC_W-1:0]  sync_out;
    logic               gp_s;
    logic [HALL_W-1:0]  hall_s;
    logic [2:0]         cond_s;   // {hot, uv, ov}
    logic [FAULT_W-1:0] fault_s;
    logic               lin_s;

    irq_sync_bank #(.W(SYNC_W), .RST_VAL(1'b0)) u_sync_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({gp_in, hall_in, hot_in, uv_in, ov_in, fault_evt}),
        .d_out (sync_out)
    );
    assign {gp_s, hall_s, cond_s, fault_s} = sync_out;

    irq_sync_bank #(.W(1), .RST_VAL(1'b1)) u_sync_lin (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (lin_rx),
        .d_out (lin_s)
    );

    // write decode
    logic wr_flags, wr_mask, wr_fl, wr_fh, wr_tl, wr_th;
    assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);
    assign wr_fl    = bus_wr && (bus_addr == A_FAULT_L);
    assign wr_fh    = bus_wr && (bus_addr == A_FAULT_H);
    assign wr_tl    = bus_wr && (bus_addr == A_THR_L);
    assign wr_th    = bus_wr && (bus_addr == A_THR_H);

    // dominant-time threshold
    logic [15:0] thr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= THR_RST;
        end else begin
            if (wr_tl) thr_q[7:0]  <= bus_wdata;
            if (wr_th) thr_q[15:8] <= bus_wdata;
        end
    end

    // LIN dominant monitor
    logic       lin_long;
    lin_state_t lin_st;
    irq_lin_monitor #(.CNT_W(CNT_W)) u_lin (
        .clk      (clk),
        .rst_n    (rst_n),
        .lin_s    (lin_s),
        .thr      (CNT_W'(thr_q)),
        .long_evt (lin_long),
        .state    (lin_st)
    );

    // edge detection; history follows the input in every mode
    logic              gp_prev;
    logic [HALL_W-1:0] hall_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_prev   <= 1'b0;
            hall_prev <= '0;
        end else begin
            gp_prev   <= gp_s;
            hall_prev <= hall_s;
        end
    end

    // fault register
    logic [15:0]        fault_clr16;
    logic [FAULT_W-1:0] fault_q;
    logic               psf_any;
    assign fault_clr16 = {(wr_fh ? bus_wdata : 8'h00), (wr_fl ? bus_wdata : 8'h00)};

    irq_fault_bank #(.W(FAULT_W)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (fault_s),
        .clr_vec (fault_clr16[FAULT_W-1:0]),
        .bits_q  (fault_q),
        .any     (psf_any)
    );

    // flag register
    logic [DATA_W-1:0] set_vec, clr_vec, flags_q, flag_view;
    always_comb begin
        set_vec         = '0;
        set_vec[B_GP]   = run_mode & (gp_s ^ gp_prev);
        set_vec[B_HALL] = run_mode & (|(hall_s ^ hall_prev));
        set_vec[B_LIN]  = lin_long;
        set_vec[B_HOT]  = cond_s[2];
        set_vec[B_UV]   = cond_s[1];
        set_vec[B_OV]   = cond_s[0];
    end
    assign clr_vec = wr_flags ? bus_wdata : '0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_flag
        if (W1C_BITS[i]) begin : g_w1c
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          flags_q[i] <= 1'b0;
                else if (set_vec[i]) flags_q[i] <= 1'b1;
                else if (clr_vec[i]) flags_q[i] <= 1'b0;
            end
        end else begin : g_none
            assign flags_q[i] = 1'b0;
        end
    end
    assign flag_view = flags_q | {{(DATA_W-1){1'b0}}, psf_any};

    // mask register
    logic [DATA_W-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata & MASK_BITS;
    end

    // registered request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_view & mask_q);
    end

    // read mux
    logic [15:0] fault16;
    assign fault16 = 16'(fault_q);
    always_comb begin
        case (bus_addr)
            A_FLAGS:   bus_rdata = flag_view;
            A_MASK:    bus_rdata = mask_q;
            A_FAULT_L: bus_rdata = fault16[7:0];
            A_FAULT_H: bus_rdata = fault16[15:8];
            A_THR_L:   bus_rdata = thr_q[7:0];
            A_THR_H:   bus_rdata = thr_q[15:8];
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
    import irq_flag_pkg::*;
#(
    parameter int unsigned FAULT_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_mode,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [DATA_W-1:0]  flag_view,
    input logic [DATA_W-1:0]  mask_q,
    input logic [FAULT_W-1:0] fault_q,
    input logic [2:0]         cond_s,
    input lin_state_t         lin_st,
    input logic               irq
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == A_FLAGS) || (bus_addr == A_MASK)) |-> !bus_rdata[B_RSVD]);

    assert_gp_run_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_view[B_GP]) |-> $past(run_mode));

    assert_hall_run_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_view[B_HALL]) |-> $past(run_mode));

    assert_lin_from_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_view[B_LIN]) |-> $past(lin_st == LIN_DOM_LONG));

    assert_wr0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_FLAGS) && !bus_wdata[B_GP] && flag_view[B_GP])
        |=> flag_view[B_GP]);

    // R10: set has priority over a same-cycle clear for the condition flags
    assert_cond_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond_s) |=> ((flag_view[3:1] & $past(cond_s)) == $past(cond_s)));

    assert_psf_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_FLAGS) |-> (bus_rdata[B_PSF] == (|fault_q)));

    assert_irq_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(flag_view & mask_q)));
endmodule

bind irq_flag_ctrl irq_flag_chk #(.FAULT_W(FAULT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_mode  (run_mode),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flag_view (flag_view),
    .mask_q    (mask_q),
    .fault_q   (fault_q),
    .cond_s    (cond_s),
    .lin_st    (lin_st),
    .irq       (irq)
);

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_mode = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        gp_in = 1'b0;
    logic [1:0]  hall_in = 2'b00;
    logic        lin_rx = 1'b1;
    logic        hot_in = 1'b0;
    logic        uv_in = 1'b0;
    logic        ov_in = 1'b0;
    logic [10:0] fault_evt = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .gp_in(gp_in), .hall_in(hall_in),
        .lin_rx(lin_rx), .hot_in(hot_in), .uv_in(uv_in), .ov_in(ov_in),
        .fault_evt(fault_evt), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] fl;
        logic [7:0] exp_fl;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(4'hA, v); check("R1 flags", 16'(v), 16'h00);
        rd(4'hB, v); check("R1 mask", 16'(v), 16'h00);
        rd(4'hC, v); check("R1 fault lo", 16'(v), 16'h00);
        rd(4'hD, v); check("R1 fault hi", 16'(v), 16'h00);
        rd(4'hE, v); check("R1 thr lo", 16'(v), 16'h40);
        check("R1 irq", 16'(irq), 16'h0);

        // R3 both edges of the general input
        gp_in = 1'b1; tick(4);
        rd(4'hA, v); check("R3 rise", 16'(v[7]), 16'h1);
        wr(4'hA, 8'h00); rd(4'hA, v); check("R6 write0 keeps", 16'(v[7]), 16'h1);
        wr(4'hA, 8'h80); rd(4'hA, v); check("R6 write1 clears", 16'(v[7]), 16'h0);
        gp_in = 1'b0; tick(4);
        rd(4'hA, v); check("R3 fall", 16'(v[7]), 16'h1);
        wr(4'hA, 8'h80);
        // R3 low-power: edges ignored, also after the return to run mode
        run_mode = 1'b0;
        gp_in = 1'b1; tick(3); gp_in = 1'b0; tick(3); gp_in = 1'b1; tick(4);
        rd(4'hA, v); check("R3 low-power ignored", 16'(v[7]), 16'h0);
        run_mode = 1'b1; tick(4);
        rd(4'hA, v); check("R3 no late set", 16'(v[7]), 16'h0);
        gp_in = 1'b0; tick(4); wr(4'hA, 8'h80);

        // R4 all hall transitions
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    hall_in = 2'(a); tick(4);
                    wr(4'hA, 8'h40);
                    rd(4'hA, v); check("R4 cleared before change", 16'(v[6]), 16'h0);
                    hall_in = 2'(b); tick(4);
                    rd(4'hA, v); check("R4 change sets", 16'(v[6]), 16'h1);
                end
            end
        end
        wr(4'hA, 8'h40);
        run_mode = 1'b0; hall_in = ~hall_in; tick(4);
        rd(4'hA, v); check("R4 low-power ignored", 16'(v[6]), 16'h0);
        run_mode = 1'b1; tick(2);

        // R5 LIN dominant threshold 8
        wr(4'hE, 8'd8); wr(4'hF, 8'd0);
        rd(4'hE, v); check("R2 thr lo readback", 16'(v), 16'h08);
        lin_rx = 1'b0; tick(3); lin_rx = 1'b1; tick(6);
        rd(4'hA, v); check("R5 short pulse", 16'(v[5]), 16'h0);
        lin_rx = 1'b0; tick(30);
        rd(4'hA, v); check("R5 no set while dominant", 16'(v[5]), 16'h0);
        lin_rx = 1'b1; tick(6);
        rd(4'hA, v); check("R5 long pulse", 16'(v[5]), 16'h1);
        wr(4'hA, 8'h20); rd(4'hA, v); check("R6 LIN clear", 16'(v[5]), 16'h0);

        // R7 condition flags
        hot_in = 1'b1; uv_in = 1'b1; ov_in = 1'b1; tick(4);
        rd(4'hA, v); check("R7 set", 16'(v[3:1]), 16'h7);
        wr(4'hA, 8'h0E); rd(4'hA, v); check("R10 clear blocked", 16'(v[3:1]), 16'h7);
        hot_in = 1'b0; uv_in = 1'b0; ov_in = 1'b0; tick(4);
        rd(4'hA, v); check("R7 sticky", 16'(v[3:1]), 16'h7);
        wr(4'hA, 8'h0A); rd(4'hA, v); check("R7 partial clear", 16'(v[3:1]), 16'h2);
        wr(4'hA, 8'h04); rd(4'hA, v); check("R7 clear", 16'(v[3:1]), 16'h0);

        // R8 walk each fault bit
        for (int k = 0; k < 11; k++) begin
            logic [15:0] ef;
            ef = 16'(1) << k;
            fault_evt = 11'(ef); tick(1); fault_evt = '0; tick(4);
            rd(4'hC, v); check("R8 fault lo", 16'(v), 16'(ef[7:0]));
            rd(4'hD, v); check("R8 fault hi", 16'(v), 16'(ef[15:8]));
            rd(4'hA, v); check("R8 psf set", 16'(v[0]), 16'h1);
            wr(4'hA, 8'h01); rd(4'hA, v); check("R8 psf write ignored", 16'(v[0]), 16'h1);
            wr(ef[7:0] != 0 ? 4'hC : 4'hD, ef[7:0] != 0 ? ef[7:0] : ef[15:8]);
            rd(4'hA, v); check("R8 psf clear", 16'(v[0]), 16'h0);
        end

        // R9 exhaustive mask sweep: flags 7, 3, 0 set
        gp_in = 1'b1; hot_in = 1'b1; fault_evt[4] = 1'b1; tick(5);
        exp_fl = 8'h89;
        rd(4'hA, fl); check("R9 flag pattern", 16'(fl), 16'(exp_fl));
        for (int m = 0; m < 256; m++) begin
            wr(4'hB, 8'(m)); tick(1);
            rd(4'hB, v); check("R2 mask readback", 16'(v), 16'(8'(m) & 8'hEF));
            check("R9 irq", 16'(irq), 16'(|(8'(m) & exp_fl)));
        end
        wr(4'hB, 8'h20); tick(1); check("R9 masked", 16'(irq), 16'h0);
        rd(4'h3, v); check("R2 unmapped", 16'(v), 16'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule